// File: doc/BRIEF.md
# Timer Input Capture Unit

This block is one capture channel that sits beside a free-running timer counter. It brings an asynchronous input pin into the clock domain and watches the synchronized level for transitions. Each transition direction has its own 2-bit action selector. The selector can ignore the transition, copy the current counter value into a read-only capture register, or ask the counter to return to zero.

When a copy into the capture register happens and interrupts are enabled, the block emits a one-cycle interrupt pulse. The counter and the register decoding that sits in front of the configuration inputs live outside this block. The counter answers `cnt_clr_o` by clearing itself. The configuration fields are expected to come out of reset at zero, which leaves every action disabled.

Top module: `icu_capture`

## Requirements
- R1: With `rise_mode_i` = 1 (capture), a 0-to-1 transition of `pin_i` loads `cap_value_o` with the `count_i` value present in the cycle the transition is detected.
- R2: With `fall_mode_i` = 1 (capture), a 1-to-0 transition of `pin_i` loads `cap_value_o` in the same way.
- R3: Mode value 2 (clear) on either selector makes `cnt_clr_o` high for exactly one cycle on the matching transition, and `cap_value_o` keeps its value.
- R4: Mode values 0 (off) and 3 (reserved) produce no action: `cap_value_o`, `cnt_clr_o` and `irq_o` stay unchanged or low.
- R5: When `irq_en_i` = 1, every capture load drives `irq_o` high for one cycle. When `irq_en_i` = 0, the load still happens and `irq_o` stays low.
- R6: Both selectors may be active together. Each transition then performs its own selector's action independently, so a clear on one edge does not disturb a value captured on the other.
- R7: After reset, `cap_value_o` is 0 and `cnt_clr_o` and `irq_o` are low.
- R8: The pin passes through a two-flop synchronizer followed by one edge-history flop. The action outputs change on the third rising clock edge after a change of `pin_i`, and never before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Raw external capture pin |
| count_i | input | 16 | Current timer counter value |
| rise_mode_i | input | 2 | Action on a 0-to-1 transition: 0 off, 1 capture, 2 clear, 3 reserved |
| fall_mode_i | input | 2 | Action on a 1-to-0 transition, same encoding |
| irq_en_i | input | 1 | Enables the interrupt pulse on capture loads |
| cap_value_o | output | 16 | Captured counter value, read-only |
| cnt_clr_o | output | 1 | One-cycle request to clear the counter |
| irq_o | output | 1 | One-cycle interrupt pulse per capture load |

## Verification
The assertions assume two things about the inputs. First, the mode selectors and the interrupt enable are steady across the cycle in which an edge is detected. Second, the pin is held long enough to pass the synchronizer. The bench meets both by driving every input only on the falling clock edge. It changes the configuration only while the pin is idle, and it holds each pin level for at least five cycles. It also keeps `count_i` constant around each transition, so each expected captured value is a single known number.

// File: rtl/icu_pkg.sv
package icu_pkg;
    typedef enum logic [1:0] {
        ACT_OFF     = 2'd0,
        ACT_CAPTURE = 2'd1,
        ACT_CLEAR   = 2'd2,
        ACT_RSVD    = 2'd3
    } edge_act_e;
endpackage

// File: rtl/icu_pin_sync.sv
module icu_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], pin_i};
        s_d.prev  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign rise_o = s_q.chain[STAGES-1] & ~s_q.prev;
    assign fall_o = ~s_q.chain[STAGES-1] & s_q.prev;

    // R8: a detected rise needs a low level first, so it cannot repeat next cycle
    p_rise_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);
    p_fall_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |=> !fall_o);
endmodule

// File: rtl/icu_edge_action.sv
module icu_edge_action
    import icu_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       hit_i,
    output logic       cap_o,
    output logic       clr_o
);
    edge_act_e act;

    always_comb begin
        act   = edge_act_e'(mode_i);
        cap_o = 1'b0;
        clr_o = 1'b0;
        if (hit_i) begin
            unique case (act)
                ACT_CAPTURE: cap_o = 1'b1;
                ACT_CLEAR:   clr_o = 1'b1;
                default:     ;
            endcase
        end
    end
endmodule

// File: rtl/icu_capture.sv
module icu_capture
    import icu_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pin_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [1:0]       rise_mode_i,
    input  logic [1:0]       fall_mode_i,
    input  logic             irq_en_i,
    output logic [CNT_W-1:0] cap_value_o,
    output logic             cnt_clr_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cap;
        logic             clr;
        logic             irq;
    } cap_st_t;

    cap_st_t st_d, st_q;
    logic rise_hit, fall_hit;
    logic rise_cap, rise_clr, fall_cap, fall_clr;
    logic load;

    icu_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (pin_i),
        .rise_o (rise_hit),
        .fall_o (fall_hit)
    );

    icu_edge_action u_rise_act (
        .mode_i (rise_mode_i),
        .hit_i  (rise_hit),
        .cap_o  (rise_cap),
        .clr_o  (rise_clr)
    );

    icu_edge_action u_fall_act (
        .mode_i (fall_mode_i),
        .hit_i  (fall_hit),
        .cap_o  (fall_cap),
        .clr_o  (fall_clr)
    );

    assign load = rise_cap | fall_cap;

    always_comb begin
        st_d     = st_q;
        // the counter value sampled here predates any clear it answers
        if (load) st_d.cap = count_i;
        st_d.clr = rise_clr | fall_clr;
        st_d.irq = load & irq_en_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cap_value_o = st_q.cap;
    assign cnt_clr_o   = st_q.clr;
    assign irq_o       = st_q.irq;

    // R5: an interrupt pulse only follows an enabled capture
    p_irq_needs_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> $past(irq_en_i) && $past(load));
    // R4: capture value moves only after a capture action
    p_cap_only_on_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(cap_value_o) |-> $past(load));
    // R3: a clear request needs a selector in clear mode
    p_clr_needs_mode_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_clr_o |-> ($past(rise_mode_i) == ACT_CLEAR) || ($past(fall_mode_i) == ACT_CLEAR));
    // R6: rise and fall never act in the same cycle
    p_one_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({rise_hit, fall_hit}));
endmodule

// File: tb/icu_capture_tb.sv
module icu_capture_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        pin_i = 1'b0;
    logic [15:0] count_i = '0;
    logic [1:0]  rise_mode_i = '0;
    logic [1:0]  fall_mode_i = '0;
    logic        irq_en_i = 1'b0;
    logic [15:0] cap_value_o;
    logic        cnt_clr_o;
    logic        irq_o;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    icu_capture dut_i (
        .clk_i, .rst_ni, .pin_i, .count_i, .rise_mode_i, .fall_mode_i,
        .irq_en_i, .cap_value_o, .cnt_clr_o, .irq_o
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // change the pin, check silence before the 3rd edge, outputs at it, and release after
    task automatic edge_step(input logic lvl, input logic [15:0] cnt, input string req,
                             input logic [15:0] exp_cap, input logic exp_clr, input logic exp_irq);
        @(negedge clk_i);
        count_i = cnt;
        pin_i   = lvl;
        repeat (2) @(posedge clk_i);
        #(CLK_PERIOD/4);
        chk({req, " early clr R8"}, cnt_clr_o, 0);
        chk({req, " early irq R8"}, irq_o, 0);
        @(posedge clk_i);
        #(CLK_PERIOD/4);
        chk({req, " cap"}, cap_value_o, exp_cap);
        chk({req, " clr"}, cnt_clr_o, exp_clr);
        chk({req, " irq"}, irq_o, exp_irq);
        @(posedge clk_i);
        #(CLK_PERIOD/4);
        chk({req, " clr pulse"}, cnt_clr_o, 0);
        chk({req, " irq pulse"}, irq_o, 0);
        repeat (2) @(posedge clk_i);
    endtask

    task automatic cfg(input logic [1:0] r, input logic [1:0] f, input logic en);
        @(negedge clk_i);
        rise_mode_i = r;
        fall_mode_i = f;
        irq_en_i    = en;
    endtask

    task automatic t_reset;
        #(CLK_PERIOD/4);
        chk("R7 cap after reset", cap_value_o, 0);
        chk("R7 clr after reset", cnt_clr_o, 0);
        chk("R7 irq after reset", irq_o, 0);
    endtask

    task automatic t_rise_capture;
        cfg(2'd1, 2'd0, 1'b1);
        edge_step(1'b1, 16'h1234, "R1 rise capture", 16'h1234, 0, 1);
        edge_step(1'b0, 16'h5555, "R4 fall off", 16'h1234, 0, 0);
    endtask

    task automatic t_fall_capture;
        cfg(2'd0, 2'd1, 1'b1);
        edge_step(1'b1, 16'h0F0F, "R4 rise off", 16'h1234, 0, 0);
        edge_step(1'b0, 16'hBEEF, "R2 fall capture", 16'hBEEF, 0, 1);
    endtask

    task automatic t_clear;
        cfg(2'd2, 2'd0, 1'b1);
        edge_step(1'b1, 16'h7777, "R3 rise clear", 16'hBEEF, 1, 0);
        cfg(2'd0, 2'd2, 1'b1);
        edge_step(1'b0, 16'h8888, "R3 fall clear", 16'hBEEF, 1, 0);
    endtask

    task automatic t_reserved;
        cfg(2'd3, 2'd3, 1'b1);
        edge_step(1'b1, 16'hAAAA, "R4 rise reserved", 16'hBEEF, 0, 0);
        edge_step(1'b0, 16'hCCCC, "R4 fall reserved", 16'hBEEF, 0, 0);
    endtask

    task automatic t_irq_disabled;
        cfg(2'd1, 2'd1, 1'b0);
        edge_step(1'b1, 16'h0042, "R5 no irq rise", 16'h0042, 0, 0);
        edge_step(1'b0, 16'hFFFF, "R5 no irq fall", 16'hFFFF, 0, 0);
    endtask

    task automatic t_both_edges;
        cfg(2'd1, 2'd2, 1'b1);
        edge_step(1'b1, 16'h2468, "R6 rise capture", 16'h2468, 0, 1);
        edge_step(1'b0, 16'h1357, "R6 fall clear keeps cap", 16'h2468, 1, 0);
        cfg(2'd1, 2'd1, 1'b1);
        edge_step(1'b1, 16'h0001, "R6 both capture rise", 16'h0001, 0, 1);
        edge_step(1'b0, 16'h8000, "R6 both capture fall", 16'h8000, 0, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk_i);
        t_reset();
        @(negedge clk_i);
        rst_ni = 1'b1;
        repeat (2) @(posedge clk_i);
        t_rise_capture();
        t_fall_capture();
        t_clear();
        t_reserved();
        t_irq_disabled();
        t_both_edges();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule